// File: doc/BRIEF.md
# External Clock Presence Detector and Timing Source Selector

This block decides which clock paces the LED sequencer: an external low-frequency clock pin or the internal oscillator. Everything runs in one system clock domain. The internal oscillator arrives as a one-cycle tick pulse. The external pin is sampled, synchronized and reduced to rising-edge pulses. The selection is made as a choice of which pulse stream becomes the timing enable, not as a clock multiplexer.

Presence is judged over fixed windows of internal ticks. A window passes when enough external rising edges fall inside it, so a slow clock or a pin stuck at either level fails the window. There is no upper frequency limit, so a clock that is too fast still counts as present. A small state machine qualifies the external clock. Its states are ST_INTERNAL (not qualified), ST_QUALIFY (one window has passed) and ST_EXTERNAL (qualified). Its transitions are:
- ST_INTERNAL to ST_QUALIFY on a passing window.
- ST_QUALIFY to ST_EXTERNAL on a second passing window in a row.
- ST_QUALIFY or ST_EXTERNAL back to ST_INTERNAL on any failing window.
- Any state to ST_INTERNAL whenever detection is disabled.

A 2-bit source field forces the external clock, forces the internal clock, or hands the choice to the qualifier.

Top module: `extclk_monitor`

## Requirements
- R1: Source field encoding. 2'b00 forces the external clock (`use_ext`=1). 2'b01 and 2'b11 force the internal clock (`use_ext`=0). This holds whatever detection reports.
- R2: With source 2'b10 (automatic), `use_ext` is 1 exactly when the qualifier is in ST_EXTERNAL, and 0 otherwise.
- R3: A window of 64 internal ticks containing fewer than 30 synchronized external rising edges fails. A clock of roughly a third of that rate never qualifies.
- R4: A pin stuck at 0, or stuck at 1, never qualifies.
- R5: A clock far faster than nominal, down to one toggle per system cycle, qualifies. No over-frequency check exists.
- R6: Qualification needs two consecutive passing windows. Counting ticks from the cycle detection is enabled, `use_ext` in automatic mode is still 0 after the 127th tick and becomes 1 with the 128th. A failing window between two passing windows restarts the count.
- R7: A single failing window moves ST_EXTERNAL back to ST_INTERNAL. Automatic mode then selects internal.
- R8: While `det_en` is 0, the window counters are cleared, the qualifier is held in ST_INTERNAL from the next cycle, and `ext_used` reads 0. Automatic mode uses the internal clock. Source 2'b00 still selects external.
- R9: `ext_used` is 1 exactly when detection is enabled, the qualifier is in ST_EXTERNAL and `use_ext` is 1.
- R10: `time_en` equals `int_tick` while `use_ext` is 0. While `use_ext` is 1, `time_en` pulses once per external rising edge, after a two-flop synchronizer plus an edge register.
- R11: After reset the qualifier is in ST_INTERNAL, so `ext_used` is 0 and automatic mode selects internal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | External clock pin, asynchronous to clk |
| int_tick | input | 1 | One-cycle pulse per internal oscillator period |
| src_sel | input | 2 | Clock source field (00 ext, 01 int, 10 auto, 11 int) |
| det_en | input | 1 | Presence detection enable |
| use_ext | output | 1 | 1 = external clock paces timing |
| ext_used | output | 1 | Status: external clock detected and in use |
| time_en | output | 1 | Timing enable pulse for the sequencer |

## Verification
The assertions check on every cycle that ST_EXTERNAL is entered only from ST_QUALIFY on a passing window, and that a failing window always lands in ST_INTERNAL. They also check that disabling detection forces ST_INTERNAL, that the edge counter restarts after each window, and that the edge pulse never lasts two cycles. Only the bench scenarios can show the frequency judgement itself. These cover the exact 128th-tick qualification point, the restart after an interleaved failure, stuck and slow pins versus an over-fast one, and the source-field decoding checked against bench-computed expectations. The pulse counts on `time_en` under each source are also checked only by the bench.

// File: rtl/extclk_pkg.sv
package extclk_pkg;

    typedef enum logic [1:0] {
        SRC_EXT     = 2'b00,
        SRC_INT     = 2'b01,
        SRC_AUTO    = 2'b10,
        SRC_INT_ALT = 2'b11
    } src_sel_e;

    typedef enum logic [1:0] {
        ST_INTERNAL = 2'd0,
        ST_QUALIFY  = 2'd1,
        ST_EXTERNAL = 2'd2
    } qual_state_e;

    localparam int unsigned DEF_WINDOW_TICKS = 64;
    localparam int unsigned DEF_MIN_EDGES    = 30;
    localparam int unsigned DEF_SYNC_STAGES  = 2;

endpackage

// File: rtl/extclk_edge_sync.sv
module extclk_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic [STAGES-1:0] sreg;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sreg <= '0;
                else        sreg <= pin;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sreg <= '0;
                else        sreg <= {sreg[STAGES-2:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sreg[STAGES-1];
    end

    assign rise = sreg[STAGES-1] & ~prev_q;

    // R10: an edge pulse is a single cycle wide
    p_rise_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/extclk_window_check.sv
module extclk_window_check #(
    parameter int unsigned WINDOW_TICKS = 64,
    parameter int unsigned MIN_EDGES    = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic int_tick,
    input  logic ext_rise,
    output logic win_done,
    output logic win_ok
);
    localparam int unsigned TW = (WINDOW_TICKS > 1) ? $clog2(WINDOW_TICKS) : 1;
    localparam int unsigned EW = $clog2(MIN_EDGES + 1);
    localparam logic [TW-1:0] LAST_TICK = TW'(WINDOW_TICKS - 1);
    localparam logic [EW-1:0] EDGE_MIN  = EW'(MIN_EDGES);

    logic [TW-1:0] tick_cnt;
    logic [EW-1:0] edge_cnt;
    logic [EW-1:0] edges_now;

    // saturating count including an edge in the current cycle
    always_comb begin
        if (ext_rise && (edge_cnt != EDGE_MIN)) edges_now = edge_cnt + 1'b1;
        else                                    edges_now = edge_cnt;
    end

    assign win_done = int_tick && (tick_cnt == LAST_TICK) && !clear;
    assign win_ok   = (edges_now >= EDGE_MIN);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            tick_cnt <= '0;
            edge_cnt <= '0;
        end else if (win_done) begin
            tick_cnt <= '0;
            edge_cnt <= '0;
        end else begin
            if (int_tick) tick_cnt <= tick_cnt + 1'b1;
            edge_cnt <= edges_now;
        end
    end

    // R3: every window starts counting edges from zero
    p_window_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |=> (edge_cnt == '0));

    // R3: the edge counter never passes its threshold
    p_edge_saturate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        edge_cnt <= EDGE_MIN);

endmodule

// File: rtl/extclk_qual_fsm.sv
module extclk_qual_fsm
    import extclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic det_en,
    input  logic win_done,
    input  logic win_ok,
    output logic ext_present
);
    qual_state_e state_q;
    qual_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (!det_en) begin
            state_d = ST_INTERNAL;
        end else if (win_done) begin
            unique case (state_q)
                ST_INTERNAL: state_d = win_ok ? ST_QUALIFY  : ST_INTERNAL;
                ST_QUALIFY:  state_d = win_ok ? ST_EXTERNAL : ST_INTERNAL;
                ST_EXTERNAL: state_d = win_ok ? ST_EXTERNAL : ST_INTERNAL;
                default:     state_d = ST_INTERNAL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_INTERNAL;
        else        state_q <= state_d;
    end

    always_comb begin
        ext_present = 1'b0;
        unique case (state_q)
            ST_INTERNAL: ext_present = 1'b0;
            ST_QUALIFY:  ext_present = 1'b0;
            ST_EXTERNAL: ext_present = 1'b1;
            default:     ext_present = 1'b0;
        endcase
    end

    // R6: external state is reached only from the qualify state on a pass
    p_two_passes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXTERNAL && $past(state_q) != ST_EXTERNAL) |->
        ($past(state_q) == ST_QUALIFY && $past(win_done) && $past(win_ok)));

    // R7: any failing window lands in the internal state
    p_fail_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && !win_ok) |=> (state_q == ST_INTERNAL));

    // R8: detection disabled holds the qualifier internal
    p_disabled_internal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en |=> (state_q == ST_INTERNAL));

endmodule

// File: rtl/extclk_monitor.sv
module extclk_monitor
    import extclk_pkg::*;
#(
    parameter int unsigned WINDOW_TICKS = DEF_WINDOW_TICKS,
    parameter int unsigned MIN_EDGES    = DEF_MIN_EDGES,
    parameter int unsigned SYNC_STAGES  = DEF_SYNC_STAGES
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_pin,
    input  logic       int_tick,
    input  logic [1:0] src_sel,
    input  logic       det_en,
    output logic       use_ext,
    output logic       ext_used,
    output logic       time_en
);
    logic ext_rise;
    logic win_done;
    logic win_ok;
    logic ext_present;

    extclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_pin),
        .rise  (ext_rise)
    );

    extclk_window_check #(
        .WINDOW_TICKS (WINDOW_TICKS),
        .MIN_EDGES    (MIN_EDGES)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!det_en),
        .int_tick (int_tick),
        .ext_rise (ext_rise),
        .win_done (win_done),
        .win_ok   (win_ok)
    );

    extclk_qual_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .det_en      (det_en),
        .win_done    (win_done),
        .win_ok      (win_ok),
        .ext_present (ext_present)
    );

    always_comb begin
        use_ext = 1'b0;
        unique case (src_sel_e'(src_sel))
            SRC_EXT:     use_ext = 1'b1;
            SRC_INT:     use_ext = 1'b0;
            SRC_AUTO:    use_ext = ext_present;
            SRC_INT_ALT: use_ext = 1'b0;
            default:     use_ext = 1'b0;
        endcase
    end

    assign ext_used = det_en & ext_present & use_ext;
    assign time_en  = use_ext ? ext_rise : int_tick;

endmodule

// File: tb/extclk_monitor_bench.sv
module extclk_monitor_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_pin = 1'b0;
    logic       int_tick = 1'b0;
    logic [1:0] src_sel = 2'b01;
    logic       det_en = 1'b0;
    logic       use_ext;
    logic       ext_used;
    logic       time_en;

    int nvec = 0;
    int nbad = 0;
    int hp = 0;
    bit stuck_lvl = 1'b0;
    int pin_rises = 0;
    int tick_seen = 0;
    int ten_seen = 0;

    always #10 clk = ~clk;

    extclk_monitor u_extclk_monitor (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_pin  (ext_pin),
        .int_tick (int_tick),
        .src_sel  (src_sel),
        .det_en   (det_en),
        .use_ext  (use_ext),
        .ext_used (ext_used),
        .time_en  (time_en)
    );

    // internal oscillator: one tick every 32 system cycles
    initial begin
        forever begin
            repeat (31) @(negedge clk);
            int_tick = 1'b1;
            @(negedge clk);
            int_tick = 1'b0;
        end
    end

    // external pin generator
    initial begin
        forever begin
            if (hp == 0) begin
                ext_pin = stuck_lvl;
                @(negedge clk);
            end else begin
                repeat (hp) @(negedge clk);
                ext_pin = ~ext_pin;
                if (ext_pin) pin_rises++;
            end
        end
    end

    always @(posedge clk) begin
        if (int_tick) tick_seen++;
        if (time_en)  ten_seen++;
    end

    function automatic bit exp_use(int src, bit present);
        if (src == 0) return 1'b1;
        if (src == 2) return present;
        return 1'b0;
    endfunction

    function automatic bit exp_used(int src, bit present, bit en);
        return en && present && exp_use(src, present);
    endfunction

    task automatic chk(string tag, int act, int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_ticks(int n);
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (!int_tick);
        end
        @(negedge clk);
    endtask

    task automatic restart();
        @(negedge clk);
        det_en = 1'b0;
        @(negedge clk);
        det_en = 1'b1;
    endtask

    // counts time_en pulses over a span; compares with bench-side sources
    task automatic pulse_check(string tag, bit ext_mode);
        int t0, p0, e0, de, dp, dt;
        @(negedge clk);
        t0 = tick_seen; p0 = pin_rises; e0 = ten_seen;
        repeat (256) @(negedge clk);
        de = ten_seen - e0;
        dp = pin_rises - p0;
        dt = tick_seen - t0;
        if (ext_mode) begin
            nvec++;
            if (de < dp - 1 || de > dp + 1) begin
                nbad++;
                $display("FAIL %s: actual %0d pulses expected %0d", tag, de, dp);
            end
        end else begin
            chk(tag, de, dt);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R11: reset state
        chk("R11 ext_used in reset", ext_used, 0);
        rst_n = 1'b1;
        @(negedge clk);
        src_sel = 2'b10;
        @(negedge clk);
        chk("R11 auto after reset", use_ext, 0);
        chk("R11 status after reset", ext_used, 0);

        // R1: forced sources, detection off, no clock
        src_sel = 2'b00; @(negedge clk);
        chk("R1 src00", use_ext, 1);
        chk("R8 status off src00", ext_used, 0);
        src_sel = 2'b01; @(negedge clk);
        chk("R1 src01", use_ext, 0);
        src_sel = 2'b11; @(negedge clk);
        chk("R1 src11", use_ext, 0);

        // R6: exact qualification point
        hp = 4;
        src_sel = 2'b10;
        restart();
        wait_ticks(127);
        chk("R6 not yet after 127 ticks", use_ext, 0);
        chk("R6 status after 127 ticks", ext_used, 0);
        wait_ticks(1);
        chk("R6 qualified at 128 ticks", use_ext, 1);
        chk("R2 auto selects ext", ext_used, 1);
        pulse_check("R10 ext pulses", 1'b1);

        // R9: status versus source while qualified
        src_sel = 2'b00; @(negedge clk);
        chk("R9 src00 qualified status", ext_used, 1);
        src_sel = 2'b01; @(negedge clk);
        chk("R9 src01 qualified status", ext_used, 0);
        chk("R1 src01 qualified", use_ext, 0);
        pulse_check("R10 int pulses", 1'b0);
        src_sel = 2'b10; @(negedge clk);

        // R7: stuck low after qualification
        hp = 0; stuck_lvl = 1'b0;
        wait_ticks(128);
        chk("R7 dropped to internal", use_ext, 0);
        chk("R4 stuck0 status", ext_used, 0);

        // R6: pass, fail, pass does not qualify
        hp = 4;
        restart();
        wait_ticks(64);
        hp = 0; stuck_lvl = 1'b1;
        wait_ticks(64);
        hp = 4;
        wait_ticks(64);
        chk("R6 interleaved fail restarts", use_ext, 0);
        wait_ticks(64);
        chk("R6 requalified", use_ext, 1);

        // R8: detection disabled while qualified
        @(negedge clk);
        det_en = 1'b0;
        #1;
        chk("R8 status drops", ext_used, 0);
        @(negedge clk);
        chk("R8 auto internal", use_ext, 0);
        wait_ticks(130);
        chk("R8 stays internal", use_ext, 0);
        src_sel = 2'b00; @(negedge clk);
        chk("R8 src00 still ext", use_ext, 1);
        chk("R8 src00 status", ext_used, 0);
        src_sel = 2'b10;

        // R5: over-fast clock
        hp = 1;
        restart();
        wait_ticks(128);
        chk("R5 fast clock present", use_ext, 1);

        // R4: stuck high
        hp = 0; stuck_lvl = 1'b1;
        restart();
        wait_ticks(128);
        chk("R4 stuck1 absent", use_ext, 0);

        // R3: slow clock
        hp = 100;
        restart();
        wait_ticks(128);
        chk("R3 slow absent", use_ext, 0);

        // random mix
        for (int it = 0; it < 12; it++) begin
            int src, cls;
            bit pres;
            src = int'($urandom_range(0, 3));
            cls = int'($urandom_range(0, 3));
            case (cls)
                0: begin hp = int'($urandom_range(2, 20)); end
                1: begin hp = int'($urandom_range(60, 200)); end
                2: begin hp = 0; stuck_lvl = 1'b0; end
                default: begin hp = 0; stuck_lvl = 1'b1; end
            endcase
            pres = (cls == 0);
            src_sel = 2'(src);
            restart();
            wait_ticks(128);
            chk("R2 random use_ext", use_ext, exp_use(src, pres));
            chk("R9 random ext_used", ext_used, exp_used(src, pres, 1'b1));
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nvec++;
        nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule